// File: doc/BRIEF.md
# GF(2^84) Fixed-Exponent Power Unit

This block takes one element X of the binary extension field GF(2^84), held in polynomial basis, and returns X^t. The exponent t is fixed. It is the inverse exponent of the map X -> X^17, which is X -> X^(1+2^4). It is a single step inside a larger multivariate decryption datapath: the caller presents an operand with a one-cycle start pulse, and after a fixed latency the block answers with a one-cycle done pulse and the result.

The exponent has a regular binary form: the byte 10000111 appears ten times, followed by the nibble 1000. Because of this, the block does not use square-and-multiply. It combines four single-cycle combinational operators:

- one full-parallel field multiplier;
- a squarer;
- a 16th-power (Frobenius) map;
- a 256th-power (Frobenius) map.

A short prefix builds X^135 and X^8. A run of steps then folds in the byte pattern, shifted by 8 bit positions per pass. The pass count is set by the repeat count of the byte.

The reduction polynomial is a parameter. The three linear power maps and the multiplier's reduction network are all derived from it while the design is elaborated.

Top module: `gf_inv_power`

## Requirements
- R1: Element encoding: bit i of an operand or result is the coefficient of x^i. The field is GF(2)[x] modulo x^84 + x^5 + 1 by default. The low 84 bits of that polynomial are the parameter `POLY`, and the x^84 term is implicit. `result_o` at done equals `operand_i`^t, where t in binary, most significant bit first, is 10000111 written ten times followed by 1000.
- R2: For every nonzero X, the result raised to the 17th power equals X. An operand of 0 returns 0, and an operand of 1 returns 1.
- R3: A start pulse is accepted on a rising clock edge where `start_i` is high and no computation is in progress. `done_o` is high in the cycle after the 16th rising edge that follows the accepting edge. It is low in every cycle between the two.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: A start pulse that arrives while a computation is in progress is ignored. Both the timing and the result of the running computation are unchanged.
- R6: Once done has been signalled, `result_o` keeps its value until the next start is accepted.
- R7: After reset, `done_o` is 0 and `result_o` is 0.
- R8: A start may be accepted in the same cycle in which `done_o` is high. There is no idle gap between back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the block releases it internally in step with the clock |
| start_i | input | 1 | Requests a new exponentiation of `operand_i` |
| operand_i | input | 84 | Field element X, sampled on the accepting edge |
| done_o | output | 1 | One-cycle pulse; `result_o` is valid |
| result_o | output | 84 | X^t |

## Verification
The bound checker watches the control side on every cycle:

- the done pulse lasts one cycle;
- an accepted start always leads to a busy state;
- the distance from the accepting edge to done is exactly 16 cycles, counted by the checker's own counter, which a busy-time restart would break;
- the result does not move while the unit is idle.

The arithmetic can only be shown by the bench scenarios. These compare the result with a bit-serial square-and-multiply model over the same exponent, and confirm that the 17th power of the result returns the operand. The scenarios also cover the fixed points 0 and 1, a start injected in mid-run, and a start issued in the done cycle.

// File: rtl/gfpow_pkg.sv
package gfpow_pkg;

  // Control phases of the fixed exponentiation schedule
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SQ1,    // b <- y^2
    PH_SQMUL,  // y <- y*b, b <- b^2
    PH_P16A,   // t <- b^16
    PH_MULT,   // t <- t*y
    PH_P16B,   // t <- t^16
    PH_JOIN,   // y <- b*t, t <- t^256
    PH_LOOP    // y <- y*t, t <- t^256
  } phase_e;

  // Exponent structure: a byte pattern repeated FRAG_REPEATS times
  localparam int FRAG_REPEATS = 10;
  localparam int PREFIX_STEPS = 7;
  localparam int LOOP_PASSES  = FRAG_REPEATS - 2;
  localparam int SCHED_STEPS  = PREFIX_STEPS + LOOP_PASSES + 1;

  // Frobenius operators: log2 of the power each one raises to
  localparam int NUM_FROB = 3;
  localparam int FI_SQ    = 0;
  localparam int FI_P16   = 1;
  localparam int FI_P256  = 2;
  localparam int FROB_LOG [NUM_FROB] = '{1, 4, 8};

endpackage

// File: rtl/gf_frob.sv
// Linear map a -> a^(2^LOG2_POW) over GF(2^W).
// Column i of the matrix is x^(i * 2^LOG2_POW) mod P, computed at elaboration.
module gf_frob #(
  parameter int          W        = 84,
  parameter logic [W-1:0] POLY    = 84'h21,
  parameter int          LOG2_POW = 1
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);

  function automatic logic [W-1:0] mulx(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? POLY : '0);
  endfunction

  function automatic logic [W-1:0] fmul(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = mulx(acc);
      if (q[i]) acc = acc ^ p;
    end
    return acc;
  endfunction

  function automatic logic [W*W-1:0] build_map();
    logic [W*W-1:0] m;
    logic [W-1:0]   base;
    logic [W-1:0]   col;
    base = W'(2);
    for (int k = 0; k < LOG2_POW; k++) base = fmul(base, base);
    col = W'(1);
    for (int i = 0; i < W; i++) begin
      m[i*W +: W] = col;
      col = fmul(col, base);
    end
    return m;
  endfunction

  localparam logic [W*W-1:0] MAP = build_map();

  always_comb begin
    y_o = '0;
    for (int i = 0; i < W; i++) begin
      if (a_i[i]) y_o = y_o ^ MAP[i*W +: W];
    end
  end

endmodule

// File: rtl/gf_mul.sv
// Single-cycle GF(2^W) multiplier: (2W-1)-term carry-less product
// followed by a precomputed fold of the upper terms.
module gf_mul #(
  parameter int          W    = 84,
  parameter logic [W-1:0] POLY = 84'h21
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  localparam int PW = 2 * W - 1;

  function automatic logic [W-1:0] mulx(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? POLY : '0);
  endfunction

  // Column j: x^(W+j) mod P
  function automatic logic [(W-1)*W-1:0] build_fold();
    logic [(W-1)*W-1:0] m;
    logic [W-1:0]       v;
    v = POLY;
    for (int j = 0; j < W - 1; j++) begin
      m[j*W +: W] = v;
      v = mulx(v);
    end
    return m;
  endfunction

  localparam logic [(W-1)*W-1:0] FOLD = build_fold();

  logic [PW-1:0] prod;

  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) begin
      if (b_i[i]) prod = prod ^ ({{(W-1){1'b0}}, a_i} << i);
    end
  end

  always_comb begin
    p_o = prod[W-1:0];
    for (int j = 0; j < W - 1; j++) begin
      if (prod[W+j]) p_o = p_o ^ FOLD[j*W +: W];
    end
  end

endmodule

// File: rtl/gfpow_ctrl.sv
// Step sequencer for the fixed exponentiation schedule.
module gfpow_ctrl
  import gfpow_pkg::*;
#(
  parameter int STEPS = SCHED_STEPS
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output logic   accept_o,
  output logic   busy_o,
  output logic   done_o,
  output phase_e phase_o
);

  localparam int CW = $clog2(STEPS + 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    busy_n   = busy_q;
    cnt_n    = cnt_q;
    done_n   = 1'b0;
    accept_o = start_i & ~busy_q;
    if (accept_o) begin
      busy_n = 1'b1;
      cnt_n  = CW'(1);
    end else if (busy_q) begin
      if (cnt_q == CW'(STEPS)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    phase_o = PH_IDLE;
    if (busy_q) begin
      if (cnt_q == CW'(1))                             phase_o = PH_SQ1;
      else if (cnt_q == CW'(2) || cnt_q == CW'(3))     phase_o = PH_SQMUL;
      else if (cnt_q == CW'(4))                        phase_o = PH_P16A;
      else if (cnt_q == CW'(5))                        phase_o = PH_MULT;
      else if (cnt_q == CW'(6))                        phase_o = PH_P16B;
      else if (cnt_q == CW'(PREFIX_STEPS))             phase_o = PH_JOIN;
      else                                             phase_o = PH_LOOP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/gf_inv_power.sv
// X -> X^t over GF(2^W), t the inverse of 17 modulo 2^W - 1.
module gf_inv_power
  import gfpow_pkg::*;
#(
  parameter int          W    = 84,
  parameter logic [W-1:0] POLY = 84'h21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int STEPS = SCHED_STEPS;

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic   accept, busy;
  phase_e phase;

  gfpow_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .start_i (start_i),
    .accept_o(accept),
    .busy_o  (busy),
    .done_o  (done_o),
    .phase_o (phase)
  );

  // Datapath registers: y accumulates, b holds the X^(2^k) chain, t the shifted fragment
  logic [W-1:0] y_q, y_n, b_q, b_n, t_q, t_n;
  logic         y_en, b_en, t_en;

  logic [W-1:0] mul_a, mul_b, mul_o;
  logic [W-1:0] frob_in  [NUM_FROB];
  logic [W-1:0] frob_out [NUM_FROB];

  gf_mul #(.W(W), .POLY(POLY)) u_mul (
    .a_i(mul_a),
    .b_i(mul_b),
    .p_o(mul_o)
  );

  for (genvar g = 0; g < NUM_FROB; g++) begin : g_frob
    gf_frob #(.W(W), .POLY(POLY), .LOG2_POW(FROB_LOG[g])) u_frob (
      .a_i(frob_in[g]),
      .y_o(frob_out[g])
    );
  end

  // Operand routing
  always_comb begin
    frob_in[FI_SQ]   = (phase == PH_SQ1)  ? y_q : b_q;
    frob_in[FI_P16]  = (phase == PH_P16A) ? b_q : t_q;
    frob_in[FI_P256] = t_q;
    mul_a = y_q;
    mul_b = t_q;
    case (phase)
      PH_SQMUL: mul_b = b_q;
      PH_MULT: begin
        mul_a = t_q;
        mul_b = y_q;
      end
      PH_JOIN:  mul_a = b_q;
      default: ;
    endcase
  end

  // Next-state values and clock enables
  always_comb begin
    y_en = accept | (phase == PH_SQMUL) | (phase == PH_JOIN) | (phase == PH_LOOP);
    y_n  = accept ? operand_i : mul_o;

    b_en = (phase == PH_SQ1) | (phase == PH_SQMUL);
    b_n  = frob_out[FI_SQ];

    t_en = (phase == PH_P16A) | (phase == PH_MULT) | (phase == PH_P16B) |
           (phase == PH_JOIN) | (phase == PH_LOOP);
    t_n  = frob_out[FI_P256];
    if (phase == PH_P16A || phase == PH_P16B) t_n = frob_out[FI_P16];
    if (phase == PH_MULT)                     t_n = mul_o;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) y_q <= '0;
    else if (y_en)   y_q <= y_n;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) b_q <= '0;
    else if (b_en)   b_q <= b_n;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) t_q <= '0;
    else if (t_en)   t_q <= t_n;
  end

  assign result_o = y_q;

endmodule

// File: rtl/gfpow_checker.sv
module gfpow_checker #(
  parameter int W     = 84,
  parameter int STEPS = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);

  localparam int LW = $clog2(STEPS + 3);

  // Cycles since the last accepted start, saturating
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lat_q <= '0;
    else if (start && !busy)    lat_q <= LW'(1);
    else if (lat_q != '1 && lat_q != '0) lat_q <= lat_q + LW'(1);
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Also covers R5: a restart during busy would stretch this distance
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(STEPS + 1)));

  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(result));

endmodule

bind gf_inv_power gfpow_checker #(.W(W), .STEPS(STEPS)) u_gfpow_checker (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .start (start_i),
  .busy  (busy),
  .done  (done_o),
  .result(result_o)
);

// File: tb/gf_inv_power_bench.sv
`timescale 1ns/1ps
module gf_inv_power_bench;

  localparam int          W     = 84;
  localparam logic [W-1:0] POLY  = 84'h21;
  localparam int          STEPS = 16;
  localparam logic [W-1:0] T_EXP = {{10{8'b1000_0111}}, 4'b1000};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] operand;
  logic         done;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  gf_inv_power u_gf_inv_power (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .operand_i(operand),
    .done_o   (done),
    .result_o (result)
  );

  // ---------------- reference model ----------------
  function automatic logic [W-1:0] m_mulx(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? POLY : '0);
  endfunction

  function automatic logic [W-1:0] m_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = m_mulx(acc);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] m_pow_t(input logic [W-1:0] x);
    logic [W-1:0] r = W'(1);
    for (int i = W - 1; i >= 0; i--) begin
      r = m_mul(r, r);
      if (T_EXP[i]) r = m_mul(r, x);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] m_pow17(input logic [W-1:0] x);
    logic [W-1:0] s = x;
    for (int k = 0; k < 4; k++) s = m_mul(s, s);
    return m_mul(s, x);
  endfunction

  function automatic logic [W-1:0] rnd_elem();
    logic [W-1:0] v;
    v = {$urandom(), $urandom(), $urandom()};
    if (v == '0) v = W'(3);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start one operation; returns after the negedge following the accepting edge
  task automatic launch(input logic [W-1:0] x);
    @(negedge clk);
    start   = 1'b1;
    operand = x;
    @(negedge clk);
    start   = 1'b0;
    operand = '0;
  endtask

  // After launch: wait to the done cycle and check it
  task automatic finish_and_check(input logic [W-1:0] x, input string tag);
    logic [W-1:0] exp;
    exp = m_pow_t(x);
    repeat (STEPS - 1) @(negedge clk);
    check(done == 1'b0, {"R3 no early done ", tag}, W'(done), '0);
    @(negedge clk);
    check(done == 1'b1, {"R3 done at 16 ", tag}, W'(done), W'(1));
    check(result == exp, {"R1 result ", tag}, result, exp);
    if (x != '0)
      check(m_pow17(result) == x, {"R2 17th power ", tag}, m_pow17(result), x);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    start   = 1'b0;
    operand = '0;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R7 done in reset", W'(done), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R7 done after reset", W'(done), '0);
    check(result == '0, "R7 result after reset", result, '0);
  endtask

  task automatic t_single(input logic [W-1:0] x, input string tag);
    logic [W-1:0] held;
    launch(x);
    finish_and_check(x, tag);
    held = result;
    @(negedge clk);
    check(done == 1'b0, {"R4 pulse width ", tag}, W'(done), '0);
    check(result == held, {"R6 hold ", tag}, result, held);
  endtask

  task automatic t_fixed_points();
    launch('0);
    finish_and_check('0, "zero");
    check(result == '0, "R2 zero maps to zero", result, '0);
    launch(W'(1));
    finish_and_check(W'(1), "one");
    check(result == W'(1), "R2 one maps to one", result, W'(1));
    t_single(W'(2), "x");
    t_single('1, "all ones");
  endtask

  task automatic t_random(input int n);
    for (int i = 0; i < n; i++) t_single(rnd_elem(), "random");
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] x1, x2, held;
    x1 = rnd_elem();
    x2 = rnd_elem();
    launch(x1);
    repeat (5) @(negedge clk);
    start   = 1'b1;
    operand = x2;
    @(negedge clk);
    start   = 1'b0;
    operand = '0;
    repeat (STEPS - 7) @(negedge clk);
    check(done == 1'b0, "R5 no early done", W'(done), '0);
    @(negedge clk);
    check(done == 1'b1, "R5 done on original schedule", W'(done), W'(1));
    check(result == m_pow_t(x1), "R5 result of first operand", result, m_pow_t(x1));
    held = result;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(done == 1'b0 && result == held, "R6 idle hold", result, held);
    end
  endtask

  task automatic t_back_to_back();
    logic [W-1:0] x1, x2;
    x1 = rnd_elem();
    x2 = rnd_elem();
    launch(x1);
    finish_and_check(x1, "b2b first");
    start   = 1'b1;
    operand = x2;
    @(negedge clk);
    start   = 1'b0;
    operand = '0;
    finish_and_check(x2, "R8 b2b second");
    @(negedge clk);
    check(done == 1'b0, "R4 b2b pulse width", W'(done), '0);
  endtask

  initial begin
    t_reset();
    t_fixed_points();
    t_random(6);
    t_busy_ignore();
    t_back_to_back();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule